// File: doc/BRIEF.md
# Colour Lookup Table with Indexed Register Access

This block keeps the colour table of a display pipeline. It has 256 main colours and 4 overlay colours, 260 entries in all. Each entry holds an 8-bit red, green and blue value. Software reaches the table through a 16-byte window of 32-bit registers. It first writes an entry number into the index register. It then moves colour components one at a time through a shared data register. The component value always travels in bits 31:24 of the bus word.

A small sequencer tracks which component comes next. Its three states are PH_RED, PH_GRN and PH_BLU. Each data access, read or write, moves it PH_RED→PH_GRN, PH_GRN→PH_BLU, and PH_BLU→PH_RED. The move PH_BLU→PH_RED also advances the index. Writing the index register forces the state to PH_RED from any state. Any other access leaves the state where it is. A second data address sends component writes to the overlay entries instead of the main ones.

The display side has its own lookup port. It returns the packed 24-bit colour of any 9-bit entry number. This port works in parallel with bus traffic.

Top module: `palette_dac`

## Requirements
- R1: A write at byte offset 0 loads the index from bus_wdata[31:24] and sets the sequencer to PH_RED, even in the middle of a triplet.
- R2: Successive writes at byte offset 4 store bus_wdata[31:24] into the red, then green, then blue component of main entry `index`.
- R3: The third component access (read or write) of a triplet increments the index modulo 256 and returns the sequencer to PH_RED. The first two accesses leave the index unchanged.
- R4: Writes at byte offset 12 follow the same sequence and index increment. They store into overlay entry 256 + (index & 3), and the main entry is not touched.
- R5: A read (bus_rd without bus_wr, at any offset) returns the current component of main entry `index` in bus_rdata[31:24], with bits 23:0 zero. The value appears one cycle after the read and is held until the next read. The read then advances the sequencer.
- R6: A write to any byte offset other than 0, 4 or 12 changes no colour, no index and no sequencer state.
- R7: After reset every component is 0, except entries 255, 256 and 258, whose three components are all 255. The index is 0, the sequencer is in PH_RED, and bus_rdata is 0.
- R8: Reads and writes share one sequencer, so a triplet may mix reads and writes. Each access continues from the current component.
- R9: pix_color is {red[23:16], green[15:8], blue[7:0]} of entry pix_idx, registered one cycle after pix_idx. A component written at clock edge k is visible to a lookup sampled at edge k+1. Entry numbers 260 to 511 give 0.
- R10: When bus_wr and bus_rd are both high, only the write takes effect. The read does not advance the sequencer and bus_rdata keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one access per cycle |
| bus_rd | input | 1 | Register read strobe, one access per cycle |
| bus_addr | input | 4 | Byte offset within the 16-byte window |
| bus_wdata | input | 32 | Write data; the component or index is in bits 31:24 |
| bus_rdata | output | 32 | Last read component in bits 31:24 |
| pix_idx | input | 9 | Entry number for the display lookup |
| pix_color | output | 24 | Packed colour of the looked-up entry |

## Verification
The data register is exercised four ways: pure write triplets, pure read triplets, triplets that mix reads and writes, and triplets cut short by an index reload. Comparing these shows whether the phase is truly shared and whether a reload really restarts at red. Overlay writes are checked both at the overlay entry and at the main entry with the same index, which shows that the redirect uses only the low index bits. Writes to unused offsets are each followed by a real data write, so a phase that slipped on the ignored access lands the value in the wrong component. Index wrap from 255 to 0 is driven on both the read path and the write path.

// File: rtl/dac_pkg.sv
package dac_pkg;

    // Component sequencer states; the encoding is also the component order.
    typedef enum logic [1:0] {
        PH_RED = 2'd0,
        PH_GRN = 2'd1,
        PH_BLU = 2'd2
    } phase_e;

    // Decoded bus operation for one cycle.
    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_LOAD    = 3'd1,
        OP_MAIN_WR = 3'd2,
        OP_OVL_WR  = 3'd3,
        OP_READ    = 3'd4
    } bus_op_e;

endpackage

// File: rtl/dac_seq.sv
module dac_seq
    import dac_pkg::*;
#(
    parameter int IDX_W     = 8,
    parameter int OVL_W     = 2,
    parameter int COMP_W    = 8,
    parameter int ADDR_W    = 4,
    parameter int OFS_INDEX = 0,
    parameter int OFS_MAIN  = 4,
    parameter int OFS_OVL   = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [COMP_W-1:0] wbyte,
    output logic [IDX_W-1:0]  idx,
    output phase_e            phase,
    output logic              st_we,
    output logic [IDX_W:0]    st_ent,
    output logic              rd_en
);
    localparam int ENT_W = IDX_W + 1;
    localparam logic [ENT_W-1:0] OVL_BASE = ENT_W'(1 << IDX_W);

    phase_e           phase_q, phase_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    bus_op_e          op;
    logic             step;

    // Address decode; a write always wins over a read in the same cycle.
    always_comb begin
        op = OP_IDLE;
        if (wr) begin
            if (addr == ADDR_W'(OFS_INDEX))     op = OP_LOAD;
            else if (addr == ADDR_W'(OFS_MAIN)) op = OP_MAIN_WR;
            else if (addr == ADDR_W'(OFS_OVL))  op = OP_OVL_WR;
        end else if (rd) begin
            op = OP_READ;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_RED;
            idx_q   <= '0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
        end
    end

    // Next state and outputs.
    always_comb begin
        phase_d = phase_q;
        idx_d   = idx_q;
        st_we   = 1'b0;
        rd_en   = 1'b0;
        st_ent  = {1'b0, idx_q};
        step    = 1'b0;
        unique case (op)
            OP_IDLE: ;
            OP_LOAD: begin
                idx_d   = IDX_W'(wbyte);
                phase_d = PH_RED;
            end
            OP_MAIN_WR: begin
                st_we = 1'b1;
                step  = 1'b1;
            end
            OP_OVL_WR: begin
                st_we  = 1'b1;
                st_ent = OVL_BASE | ENT_W'(idx_q[OVL_W-1:0]);
                step   = 1'b1;
            end
            OP_READ: begin
                rd_en = 1'b1;
                step  = 1'b1;
            end
            default: ;
        endcase
        if (step) begin
            unique case (phase_q)
                PH_RED: phase_d = PH_GRN;
                PH_GRN: phase_d = PH_BLU;
                PH_BLU: begin
                    phase_d = PH_RED;
                    idx_d   = idx_q + 1'b1;
                end
                default: phase_d = PH_RED;
            endcase
        end
    end

    assign idx   = idx_q;
    assign phase = phase_q;

endmodule

// File: rtl/dac_store.sv
module dac_store
    import dac_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int OVL_W  = 2,
    parameter int COMP_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [IDX_W:0]      wr_ent,
    input  phase_e              comp,
    input  logic [COMP_W-1:0]   wbyte,
    input  logic                rd_en,
    input  logic [IDX_W-1:0]    rd_idx,
    output logic [DATA_W-1:0]   rdata,
    input  logic [IDX_W:0]      pix_idx,
    output logic [3*COMP_W-1:0] pix_color
);
    localparam int ENT_W = IDX_W + 1;
    localparam int RGB_W = 3 * COMP_W;
    localparam int NMAIN = 1 << IDX_W;
    localparam int NOVL  = 1 << OVL_W;
    localparam int NENT  = NMAIN + NOVL;

    logic [NENT-1:0][RGB_W-1:0] ent_vec;

    for (genvar e = 0; e < NENT; e++) begin : g_ent
        localparam logic [RGB_W-1:0] RST_VAL =
            ((e == NMAIN - 1) || (e == NMAIN) || (e == NMAIN + 2)) ? {RGB_W{1'b1}} : {RGB_W{1'b0}};
        logic [RGB_W-1:0] val_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= RST_VAL;
            end else if (we && (wr_ent == ENT_W'(e))) begin
                unique case (comp)
                    PH_RED:  val_q[RGB_W-1 -: COMP_W]    <= wbyte;
                    PH_GRN:  val_q[2*COMP_W-1 -: COMP_W] <= wbyte;
                    PH_BLU:  val_q[COMP_W-1:0]           <= wbyte;
                    default: ;
                endcase
            end
        end
        assign ent_vec[e] = val_q;
    end

    // Bus read port: main entries only, component chosen by phase.
    logic [RGB_W-1:0]  rd_entry;
    logic [COMP_W-1:0] rd_byte;
    always_comb begin
        rd_entry = ent_vec[{1'b0, rd_idx}];
        unique case (comp)
            PH_RED:  rd_byte = rd_entry[RGB_W-1 -: COMP_W];
            PH_GRN:  rd_byte = rd_entry[2*COMP_W-1 -: COMP_W];
            PH_BLU:  rd_byte = rd_entry[COMP_W-1:0];
            default: rd_byte = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= {rd_byte, {(DATA_W-COMP_W){1'b0}}};
    end

    // Display lookup port: one registered stage, independent of the bus.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pix_color <= '0;
        else        pix_color <= (pix_idx < ENT_W'(NENT)) ? ent_vec[pix_idx] : '0;
    end

endmodule

// File: rtl/palette_dac.sv
module palette_dac
    import dac_pkg::*;
#(
    parameter int IDX_W  = 8,
    parameter int OVL_W  = 2,
    parameter int COMP_W = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic [IDX_W:0]      pix_idx,
    output logic [3*COMP_W-1:0] pix_color
);
    logic [COMP_W-1:0] wbyte;
    logic              wdata_unused;
    logic [IDX_W-1:0]  cur_idx;
    phase_e            cur_phase;
    logic              st_we;
    logic [IDX_W:0]    st_ent;
    logic              rd_en;

    assign wbyte        = bus_wdata[DATA_W-1 -: COMP_W];
    assign wdata_unused = ^bus_wdata[DATA_W-COMP_W-1:0];

    dac_seq #(
        .IDX_W (IDX_W),
        .OVL_W (OVL_W),
        .COMP_W(COMP_W),
        .ADDR_W(ADDR_W)
    ) u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (bus_wr),
        .rd    (bus_rd),
        .addr  (bus_addr),
        .wbyte (wbyte),
        .idx   (cur_idx),
        .phase (cur_phase),
        .st_we (st_we),
        .st_ent(st_ent),
        .rd_en (rd_en)
    );

    dac_store #(
        .IDX_W (IDX_W),
        .OVL_W (OVL_W),
        .COMP_W(COMP_W),
        .DATA_W(DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (st_we),
        .wr_ent   (st_ent),
        .comp     (cur_phase),
        .wbyte    (wbyte),
        .rd_en    (rd_en),
        .rd_idx   (cur_idx),
        .rdata    (bus_rdata),
        .pix_idx  (pix_idx),
        .pix_color(pix_color)
    );

endmodule

// File: rtl/dac_checker.sv
module dac_checker #(
    parameter int IDX_W  = 8,
    parameter int OVL_W  = 2,
    parameter int COMP_W = 8,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic [IDX_W:0]      pix_idx,
    input logic [3*COMP_W-1:0] pix_color,
    input logic [IDX_W-1:0]    idx,
    input logic [1:0]          phase
);
    localparam int NENT = (1 << IDX_W) + (1 << OVL_W);
    localparam logic [1:0] P_RED = 2'd0;
    localparam logic [1:0] P_GRN = 2'd1;
    localparam logic [1:0] P_BLU = 2'd2;

    logic data_acc;
    logic ign_wr;
    assign data_acc = (bus_wr && (bus_addr == ADDR_W'(4) || bus_addr == ADDR_W'(12))) || (bus_rd && !bus_wr);
    assign ign_wr   = bus_wr && bus_addr != ADDR_W'(0) && bus_addr != ADDR_W'(4) && bus_addr != ADDR_W'(12);

    AST_IDX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(0)) |=> (phase == P_RED && idx == $past(bus_wdata[DATA_W-1 -: IDX_W]))); // R1

    AST_MID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && phase == P_GRN) |=> (phase == P_BLU && $stable(idx))); // R3

    AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && phase == P_BLU) |=> (phase == P_RED && idx == $past(idx) + 1'b1)); // R3

    AST_RD_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-COMP_W-1:0] == '0); // R5

    AST_IGNORED_WR: assert property (@(posedge clk) disable iff (!rst_n)
        ign_wr |=> ($stable(phase) && $stable(idx))); // R6

    AST_PIX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_idx >= (IDX_W+1)'(NENT)) |=> pix_color == '0); // R9

    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_rd) |=> $stable(bus_rdata)); // R10

endmodule

bind palette_dac dac_checker #(
    .IDX_W (IDX_W),
    .OVL_W (OVL_W),
    .COMP_W(COMP_W),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
) u_dac_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pix_idx  (pix_idx),
    .pix_color(pix_color),
    .idx      (cur_idx),
    .phase    (cur_phase)
);

// File: tb/tb_palette_dac.sv
`timescale 1ns/1ps
module tb_palette_dac;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [8:0]  pix_idx = '0;
    logic [23:0] pix_color;

    palette_dac dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pix_idx(pix_idx), .pix_color(pix_color)
    );

    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Reference model built from the requirements.
    logic [7:0] mr [260];
    logic [7:0] mg [260];
    logic [7:0] mb [260];
    logic [7:0] midx;
    int         mph;

    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_q = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic mdl_step();
        if (mph == 2) begin
            mph  = 0;
            midx = midx + 8'd1;
        end else begin
            mph++;
        end
    endtask

    task automatic mdl_write(input logic [3:0] a, input logic [7:0] b);
        int e;
        if (a == 4'd0) begin
            midx = b;
            mph  = 0;
        end else if (a == 4'd4 || a == 4'd12) begin
            e = (a == 4'd12) ? 256 + int'(midx[1:0]) : int'(midx);
            case (mph)
                0: mr[e] = b;
                1: mg[e] = b;
                default: mb[e] = b;
            endcase
            mdl_step();
        end
    endtask

    // Drivers.
    task automatic bw(input logic [3:0] a, input logic [7:0] b);
        @(negedge clk);
        bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = {b, 24'h5A5A5A};
        mdl_write(a, b);
    endtask

    task automatic br(input string tag);
        logic [7:0] v;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = 4'd4;
        case (mph)
            0: v = mr[midx];
            1: v = mg[midx];
            default: v = mb[midx];
        endcase
        exp_q.push_back({v, 24'h0});
        tag_q.push_back(tag);
        mdl_step();
    endtask

    task automatic idle();
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic pix(input int i, input string tag);
        logic [23:0] e;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0; pix_idx = 9'(i);
        e = (i < 260) ? {mr[i], mg[i], mb[i]} : 24'h0;
        @(negedge clk);
        chk(pix_color === e, tag, {8'h0, pix_color}, {8'h0, e});
    endtask

    // Monitor: a read sampled at an edge has its data by the next falling edge.
    always @(posedge clk) rd_q <= bus_rd && !bus_wr && rst_n;

    always @(negedge clk) begin
        if (rd_q) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R5 unexpected read data", bus_rdata, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(bus_rdata === e, t, bus_rdata, e);
            end
        end
    end

    initial begin
        logic [31:0] held;
        for (int i = 0; i < 260; i++) begin
            mr[i] = 8'h00; mg[i] = 8'h00; mb[i] = 8'h00;
        end
        mr[255] = 8'hFF; mg[255] = 8'hFF; mb[255] = 8'hFF;
        mr[256] = 8'hFF; mg[256] = 8'hFF; mb[256] = 8'hFF;
        mr[258] = 8'hFF; mg[258] = 8'hFF; mb[258] = 8'hFF;
        midx = 8'd0; mph = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_rdata === 32'h0, "R7 rdata after reset", bus_rdata, 32'h0);
        pix(0,   "R7 entry 0 reset");
        pix(255, "R7 entry 255 reset");
        pix(256, "R7 entry 256 reset");
        pix(257, "R7 entry 257 reset");
        pix(258, "R7 entry 258 reset");
        pix(259, "R7 entry 259 reset");
        // Index 0 after reset: read from entry 0 without loading.
        br("R7 index zero after reset");
        bw(4'd0, 8'd0);

        // Read path wraps 255 -> 0.
        bw(4'd0, 8'd255);
        br("R5 read red 255"); br("R5 read green 255"); br("R5 read blue 255");
        br("R3 read wrap to entry 0");
        idle();

        // Main write triplet, then next entry.
        bw(4'd0, 8'd10);
        bw(4'd4, 8'h12); bw(4'd4, 8'h34); bw(4'd4, 8'h56);
        bw(4'd4, 8'hAA);
        pix(10, "R2 entry 10 triplet");
        pix(11, "R3 index advanced to 11");

        // Overlay redirect: index 0x45 -> entry 257.
        bw(4'd0, 8'h45);
        bw(4'd12, 8'h0F); bw(4'd12, 8'hF0); bw(4'd12, 8'h3C);
        pix(257, "R4 overlay entry 257");
        pix(69,  "R4 main entry untouched");
        br("R4 index advanced after overlay blue");

        // Ignored offsets must not move the phase or store data.
        bw(4'd0, 8'd20);
        bw(4'd8, 8'h77); bw(4'd5, 8'h66); bw(4'd15, 8'h55);
        bw(4'd4, 8'h11);
        pix(20, "R6 ignored offsets");

        // Mixed read/write triplet on entry 10.
        bw(4'd0, 8'd10);
        br("R8 mixed read red");
        bw(4'd4, 8'h99);
        br("R8 mixed read blue");
        br("R8 next entry after mixed triplet");
        pix(10, "R8 entry 10 after mixed");

        // Write and read together: write only.
        bw(4'd0, 8'd10);
        idle();
        @(negedge clk);
        held = bus_rdata;
        bus_wr = 1'b1; bus_rd = 1'b1; bus_addr = 4'd4; bus_wdata = 32'h01000000;
        mdl_write(4'd4, 8'h01);
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk(bus_rdata === held, "R10 rdata held on write+read", bus_rdata, held);
        br("R10 read saw one step only");
        pix(10, "R10 write took effect");

        // Reload mid-triplet restarts at red.
        bw(4'd0, 8'd30);
        bw(4'd4, 8'h44);
        bw(4'd0, 8'd31);
        bw(4'd4, 8'h22);
        pix(31, "R1 reload restarts at red");
        pix(30, "R1 partial triplet kept");

        // Write path wraps 255 -> 0.
        bw(4'd0, 8'd255);
        bw(4'd4, 8'h01); bw(4'd4, 8'h02); bw(4'd4, 8'h03);
        bw(4'd4, 8'hC3);
        pix(255, "R2 entry 255 written");
        pix(0,   "R3 write wrap to entry 0");

        // Out of range lookups.
        pix(300, "R9 entry 300 reads zero");
        pix(511, "R9 entry 511 reads zero");

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R5 scoreboard drained", 32'(exp_q.size()), 32'h0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule